// File: doc/BRIEF.md
# Exclusive Two-Level Tag Cache

This block models the tag side of a two-level cache hierarchy in which the second level holds only blocks that the first level has pushed out. It takes one access at a time, made of a read/write flag and a 48-bit byte address, and decides whether the access hits in the first level, hits in the second level, or has to go to memory. No data is stored. The block keeps six running counters: memory reads, memory writes, first-level hits and misses, and second-level hits and misses.

When an access misses in the first level but hits in the second, the block leaves the second level and is installed in the first. The first level may have to make room for it. If so, the displaced block is written into the second level, and that write can push out the oldest block there, which is then discarded. When an access misses in both levels, the block comes from memory and goes into the first level only. The second level is never filled directly. Each level has its own line count and associativity, and the first level can use first-in-first-out or least-recently-used replacement. Both levels use the same block size.

Each access is accepted with a ready/valid handshake. The result comes back as a one-cycle `done` pulse, together with flags that say which level supplied the block.

Top module: `xcl_victim_hier`

## Requirements
- R1: After reset, all six counters read zero, `req_ready` is high and `done` is low.
- R2: When the block is present in the first level, the response has `resp_l1_hit`=1 and `resp_l2_hit`=0, and the first-level hit counter rises by one. The second-level contents and counters do not change.
- R3: When an access misses in the first level but finds its block in the second level, the response has `resp_l1_hit`=0 and `resp_l2_hit`=1. The block is removed from the second level and installed in the first, so no block is ever resident in both levels.
- R4: A valid block displaced from the first level during an install is written into the second level. If the target second-level set is full, its oldest-inserted block is dropped, and a later access to the dropped block misses in both levels.
- R5: When an access misses in both levels, both response flags are 0 and the memory-read counter rises by one. The block goes into the first level only.
- R6: Every write access raises the memory-write counter by one, whether it hits or misses. A write that misses in both levels therefore also raises the memory-read counter by one.
- R7: With `L1_LRU`=0, the first level replaces the way that was installed earliest in the set. With `L1_LRU`=1, it replaces the way that was accessed least recently.
- R8: The second-level hit and miss counts always add up to the first-level miss count. The memory-read count always equals the second-level miss count.
- R9: When a promotion frees a slot in a full second-level set, the block displaced from the first level in the same access takes that slot, and no other second-level block is dropped.
- R10: `req_ready` is low from the cycle after an access is accepted until its `done` pulse. `done` is high for one cycle, with at most one of the two response flags set.
- R11: The block address is the byte address shifted right by log2(`BLK_BYTES`). The set of a level is the block address modulo that level's set count (lines divided by ways). Invalid ways fill lowest-index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_ready | output | 1 | Block can accept an access |
| done | output | 1 | One-cycle pulse when an access completes |
| resp_l1_hit | output | 1 | Completed access hit in the first level |
| resp_l2_hit | output | 1 | Completed access was promoted from the second level |
| mem_rd_cnt | output | CNT_W | Memory read count |
| mem_wr_cnt | output | CNT_W | Memory write count |
| l1_hit_cnt | output | CNT_W | First-level hit count |
| l1_miss_cnt | output | CNT_W | First-level miss count |
| l2_hit_cnt | output | CNT_W | Second-level hit count |
| l2_miss_cnt | output | CNT_W | Second-level miss count |

## Verification
Two things can happen to the second level within a single access: a promotion removes a block from it, and a block displaced from the first level is written into it. The bench first fills the fully associative second level. It then hits a block there while the first-level set is full. The promoted slot has to be invalidated before the incoming block chooses where to go. So the bench checks two things with later accesses. Every block that was resident before the promotion must still hit. A block the hierarchy has already dropped must miss in both levels.

// File: rtl/xcl_victim_hier.sv
module xcl_victim_hier #(
  parameter int ADDR_W    = 48,
  parameter int BLK_BYTES = 4,
  parameter int L1_LINES  = 8,
  parameter int L1_WAYS   = 2,
  parameter bit L1_LRU    = 1'b0,
  parameter int L2_LINES  = 4,
  parameter int L2_WAYS   = 4,
  parameter int CNT_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              done,
  output logic              resp_l1_hit,
  output logic              resp_l2_hit,
  output logic [CNT_W-1:0]  mem_rd_cnt,
  output logic [CNT_W-1:0]  mem_wr_cnt,
  output logic [CNT_W-1:0]  l1_hit_cnt,
  output logic [CNT_W-1:0]  l1_miss_cnt,
  output logic [CNT_W-1:0]  l2_hit_cnt,
  output logic [CNT_W-1:0]  l2_miss_cnt
);
  localparam int OFF_W   = $clog2(BLK_BYTES);
  localparam int BA_W    = ADDR_W - OFF_W;
  localparam int L1_SETS = L1_LINES / L1_WAYS;
  localparam int L2_SETS = L2_LINES / L2_WAYS;
  localparam int STW     = 32;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_FILL, S_SPILL} st_t;
  st_t st;

  logic            l1_v [L1_LINES];
  logic [BA_W-1:0] l1_t [L1_LINES];
  logic [STW-1:0]  l1_s [L1_LINES];
  logic            l2_v [L2_LINES];
  logic [BA_W-1:0] l2_t [L2_LINES];
  logic [STW-1:0]  l2_s [L2_LINES];
  logic [STW-1:0]  l1_clk, l2_clk;

  logic [BA_W-1:0] cur_blk, spill_blk, l2_key;
  logic            cur_wr, looking;
  int              l1_set, l2_set, l1_base, l2_base;
  int              l1_hw, l1_vw, l2_hw, l2_vw;
  logic            l1_hit, l2_hit, l1_full, l2_full;
  logic [STW-1:0]  l1_min, l2_min;

  assign req_ready = (st == S_IDLE);
  assign looking   = (st == S_LOOK);
  assign l2_key    = (st == S_SPILL) ? spill_blk : cur_blk;
  assign l1_set    = int'(cur_blk % BA_W'(L1_SETS));
  assign l2_set    = int'(l2_key % BA_W'(L2_SETS));
  assign l1_base   = l1_set * L1_WAYS;
  assign l2_base   = l2_set * L2_WAYS;

  always_comb begin
    l1_hit = 1'b0; l1_hw = 0; l1_vw = 0; l1_full = 1'b1; l1_min = '1;
    for (int w = 0; w < L1_WAYS; w++) begin
      if (l1_v[l1_base+w] && l1_t[l1_base+w] == cur_blk) begin
        l1_hit = 1'b1; l1_hw = w;
      end
      if (l1_full) begin
        if (!l1_v[l1_base+w]) begin
          l1_full = 1'b0; l1_vw = w;
        end else if (l1_s[l1_base+w] < l1_min) begin
          l1_min = l1_s[l1_base+w]; l1_vw = w;
        end
      end
    end
  end

  always_comb begin
    l2_hit = 1'b0; l2_hw = 0; l2_vw = 0; l2_full = 1'b1; l2_min = '1;
    for (int w = 0; w < L2_WAYS; w++) begin
      if (l2_v[l2_base+w] && l2_t[l2_base+w] == l2_key) begin
        l2_hit = 1'b1; l2_hw = w;
      end
      if (l2_full) begin
        if (!l2_v[l2_base+w]) begin
          l2_full = 1'b0; l2_vw = w;
        end else if (l2_s[l2_base+w] < l2_min) begin
          l2_min = l2_s[l2_base+w]; l2_vw = w;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      done <= 1'b0; resp_l1_hit <= 1'b0; resp_l2_hit <= 1'b0;
      mem_rd_cnt <= '0; mem_wr_cnt <= '0;
      l1_hit_cnt <= '0; l1_miss_cnt <= '0; l2_hit_cnt <= '0; l2_miss_cnt <= '0;
      l1_clk <= '0; l2_clk <= '0;
      cur_blk <= '0; spill_blk <= '0; cur_wr <= 1'b0;
      for (int i = 0; i < L1_LINES; i++) l1_v[i] <= 1'b0;
      for (int i = 0; i < L2_LINES; i++) l2_v[i] <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          cur_blk <= req_addr[ADDR_W-1:OFF_W];
          cur_wr  <= req_write;
          st      <= S_LOOK;
        end
        S_LOOK: begin
          if (cur_wr) mem_wr_cnt <= mem_wr_cnt + 1'b1;
          if (l1_hit) begin
            l1_hit_cnt <= l1_hit_cnt + 1'b1;
            if (L1_LRU) begin
              l1_s[l1_base+l1_hw] <= l1_clk;
              l1_clk <= l1_clk + 1'b1;
            end
            resp_l1_hit <= 1'b1; resp_l2_hit <= 1'b0;
            done <= 1'b1;
            st <= S_IDLE;
          end else begin
            l1_miss_cnt <= l1_miss_cnt + 1'b1;
            resp_l1_hit <= 1'b0;
            if (l2_hit) begin
              l2_hit_cnt <= l2_hit_cnt + 1'b1;
              l2_v[l2_base+l2_hw] <= 1'b0;
              resp_l2_hit <= 1'b1;
            end else begin
              l2_miss_cnt <= l2_miss_cnt + 1'b1;
              mem_rd_cnt  <= mem_rd_cnt + 1'b1;
              resp_l2_hit <= 1'b0;
            end
            st <= S_FILL;
          end
        end
        S_FILL: begin
          l1_v[l1_base+l1_vw] <= 1'b1;
          l1_t[l1_base+l1_vw] <= cur_blk;
          l1_s[l1_base+l1_vw] <= l1_clk;
          l1_clk <= l1_clk + 1'b1;
          if (l1_full) begin
            spill_blk <= l1_t[l1_base+l1_vw];
            st <= S_SPILL;
          end else begin
            done <= 1'b1;
            st <= S_IDLE;
          end
        end
        default: begin
          l2_v[l2_base+l2_vw] <= 1'b1;
          l2_t[l2_base+l2_vw] <= spill_blk;
          l2_s[l2_base+l2_vw] <= l2_clk;
          l2_clk <= l2_clk + 1'b1;
          done <= 1'b1;
          st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/xcl_victim_hier_chk.sv
module xcl_victim_hier_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             done,
  input logic             resp_l1_hit,
  input logic             resp_l2_hit,
  input logic             looking,
  input logic             l1_hit,
  input logic             l2_hit,
  input logic [CNT_W-1:0] mem_rd_cnt,
  input logic [CNT_W-1:0] l1_miss_cnt,
  input logic [CNT_W-1:0] l2_hit_cnt,
  input logic [CNT_W-1:0] l2_miss_cnt
);
  // R3
  both_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    looking |-> !(l1_hit && l2_hit));
  // R8
  l2_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_hit_cnt + l2_miss_cnt) == l1_miss_cnt);
  // R8
  memrd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_cnt == l2_miss_cnt);
  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R10
  resp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($onehot0({resp_l1_hit, resp_l2_hit}) && req_ready));
  // R2
  l1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (looking && l1_hit) |=> ($stable(l2_hit_cnt) && $stable(l2_miss_cnt)));
endmodule

bind xcl_victim_hier xcl_victim_hier_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .resp_l1_hit(resp_l1_hit), .resp_l2_hit(resp_l2_hit),
  .looking(looking), .l1_hit(l1_hit), .l2_hit(l2_hit),
  .mem_rd_cnt(mem_rd_cnt), .l1_miss_cnt(l1_miss_cnt),
  .l2_hit_cnt(l2_hit_cnt), .l2_miss_cnt(l2_miss_cnt));

// File: tb/xcl_victim_hier_test.sv
module xcl_victim_hier_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rv = 1'b0, rw = 1'b0, rdy, dn, h1, h2;
  logic [47:0] ra = '0;
  logic [31:0] c_mrd, c_mwr, c_l1h, c_l1m, c_l2h, c_l2m;

  logic        rv2 = 1'b0, rdy2, dn2, g1, g2;
  logic [47:0] ra2 = '0;
  logic [31:0] d_mrd, d_mwr, d_l1h, d_l1m, d_l2h, d_l2m;

  xcl_victim_hier uut (
    .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_write(rw), .req_addr(ra),
    .req_ready(rdy), .done(dn), .resp_l1_hit(h1), .resp_l2_hit(h2),
    .mem_rd_cnt(c_mrd), .mem_wr_cnt(c_mwr), .l1_hit_cnt(c_l1h),
    .l1_miss_cnt(c_l1m), .l2_hit_cnt(c_l2h), .l2_miss_cnt(c_l2m));

  xcl_victim_hier #(.L1_LRU(1'b1)) uut_lru (
    .clk(clk), .rst_n(rst_n), .req_valid(rv2), .req_write(1'b0), .req_addr(ra2),
    .req_ready(rdy2), .done(dn2), .resp_l1_hit(g1), .resp_l2_hit(g2),
    .mem_rd_cnt(d_mrd), .mem_wr_cnt(d_mwr), .l1_hit_cnt(d_l1h),
    .l1_miss_cnt(d_l1m), .l2_hit_cnt(d_l2h), .l2_miss_cnt(d_l2m));

  int total = 0, bad = 0;
  logic [1:0] expq[$];
  string      tagq[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic access(logic w, logic [47:0] a, logic e1, logic e2, string tag);
    expq.push_back({e1, e2});
    tagq.push_back(tag);
    @(negedge clk);
    while (!rdy) @(negedge clk);
    rv = 1'b1; rw = w; ra = a;
    @(negedge clk);
    rv = 1'b0;
    check("R10", {31'd0, rdy}, 32'd0);
    while (!rdy) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (dn) begin
      if (expq.size() == 0) check("R10", 32'd1, 32'd0);
      else begin
        logic [1:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(t, {30'd0, h1, h2}, {30'd0, e});
      end
    end
  end

  task automatic access_lru(logic [47:0] a, logic e1, logic e2, string tag);
    @(negedge clk);
    while (!rdy2) @(negedge clk);
    rv2 = 1'b1; ra2 = a;
    @(negedge clk);
    rv2 = 1'b0;
    while (!dn2) @(negedge clk);
    check(tag, {30'd0, g1, g2}, {30'd0, e1, e2});
  endtask

  bit finished = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1", c_mrd | c_mwr | c_l1h | c_l1m | c_l2h | c_l2m, 32'd0);
    check("R1", {30'd0, rdy, dn}, 32'd2);
    // set 0 blocks: A=0x00, B=0x10, C=0x20; set 1 blocks P0..P5 (R11)
    access(0, 48'h00, 0, 0, "R5");
    access(0, 48'h10, 0, 0, "R5");
    access(1, 48'h00, 1, 0, "R2");
    access(1, 48'h20, 0, 0, "R6");
    access(0, 48'h00, 0, 1, "R3");
    access(0, 48'h10, 0, 1, "R7");
    access(0, 48'h20, 0, 1, "R4");
    access(0, 48'h04, 0, 0, "R11");
    access(0, 48'h14, 0, 0, "R11");
    access(0, 48'h24, 0, 0, "R5");
    access(0, 48'h34, 0, 0, "R5");
    access(0, 48'h44, 0, 0, "R5");
    access(0, 48'h54, 0, 0, "R4");
    access(1, 48'h00, 0, 0, "R4");
    access(0, 48'h04, 0, 0, "R4");
    access(0, 48'h10, 0, 1, "R9");
    access(0, 48'h14, 0, 0, "R4");
    access(0, 48'h34, 0, 1, "R9");
    while (expq.size() != 0) @(negedge clk);
    check("R8", c_l2h + c_l2m, c_l1m);
    check("R5", c_mrd, 32'd12);
    check("R6", c_mwr, 32'd3);
    check("R2", c_l1h, 32'd1);
    check("R8", c_l1m, 32'd17);
    check("R3", c_l2h, 32'd5);
    // R7: least-recently-used first level
    access_lru(48'h00, 0, 0, "R7");
    access_lru(48'h10, 0, 0, "R7");
    access_lru(48'h00, 1, 0, "R7");
    access_lru(48'h20, 0, 0, "R7");
    access_lru(48'h10, 0, 1, "R7");
    access_lru(48'h00, 0, 1, "R7");
    check("R8", d_mrd, 32'd3);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule